// File: doc/BRIEF.md
# True-Carry Integer Add/Subtract Unit

This block is the 32-bit add and subtract-from datapath of an integer execution pipe, together with its flag logic. Every subtraction is performed as an addition of the inverted operand, so the carry it reports is a true carry out of the top bit, never a borrow. It covers the plain, carrying and extended forms, forms whose second addend is fixed at all-ones or zero, and immediate forms. In two immediate forms, register field A names register zero and is then read as the constant zero.

The block takes both register operands, the 16-bit immediate, a 4-bit operation code, a flag that tells it field A selects register zero, the current carry bit and the current summary-overflow bit. It also takes two option requests, one for overflow recording and one for the condition field. It returns the result, the new carry, overflow and summary-overflow bits, and a 4-bit condition field. Each output flag has its own write-enable for the architectural state that the surrounding pipe holds. The outputs are registered once, so a result appears one clock after its operation is presented. Chaining carry from one operation into the next gives multiword arithmetic.

Top module: `tc_addsub`

## Requirements
- R1: While `rst_n` is low at a clock edge, all outputs are cleared on that edge, including `out_valid` and every write-enable, whatever `in_valid` holds.
- R2: An operation presented with `in_valid` high appears on the outputs one clock later with `out_valid` high. While `out_valid` is low, every write-enable is low.
- R3: The add family, with op codes ADD=0, ADDC=1, ADDE=2, ADDME=3 and ADDZE=4, returns A+B, A+B, A+B+CA, A+CA+0xFFFFFFFF and A+CA. CA is `ca_in`, and all sums are modulo 2^32.
- R4: The subtract-from family, with op codes SUBF=5, SUBFC=6, SUBFE=7, SUBFME=8 and SUBFZE=9, returns ~A+B+1 (that is, B-A), ~A+B+CA, ~A+CA+0xFFFFFFFF and ~A+CA. SUBF and SUBFC share the first formula.
- R5: The immediate forms are ADDI=10 (A+sext(imm)), ADDIS=11 (A+{imm,16'h0000}), ADDIC=12 (A+sext(imm)) and SUBFIC=13 (~A+sext(imm)+1).
- R6: When `a_is_r0` is high, ADDI and ADDIS use zero for A. ADDIC and all other forms always use `opnd_a`.
- R7: `ca_we` is high for ADDC, ADDE, ADDME, ADDZE, SUBFC, SUBFE, SUBFME, SUBFZE, ADDIC and SUBFIC, and `ca_out` is then the carry out of bit 31. ADD, SUBF, ADDI and ADDIS never raise `ca_we`. A value output reads 0 whenever its enable is low.
- R8: `ov_we` is high when `ovf_req` is high and the op is neither ADDI nor ADDIS. `ov_out` is then 1 exactly when the two addends (after inversion) share a sign and the 32-bit result has the other sign.
- R9: `so_we` equals `ov_we`, and `so_out` is `so_in` OR the new overflow bit, so a zero overflow leaves summary overflow unchanged.
- R10: `cr_we` is high when `rec_req` is high and the op is neither ADDI nor ADDIS. `cr_out` is {LT,GT,EQ,SO}: bit 3 is result bit 31, bit 1 is set for a zero result, bit 2 is set when the result is neither negative nor zero, and bit 0 is the updated summary overflow (`so_out` when `ov_we`, else `so_in`).
- R11: Op codes 14 and 15 produce `out_valid` high with result 0 and every write-enable low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation code (see R3, R4, R5, R11) |
| opnd_a | input | 32 | Register operand A |
| opnd_b | input | 32 | Register operand B |
| imm | input | 16 | Immediate field |
| a_is_r0 | input | 1 | Field A names register zero |
| ca_in | input | 1 | Current carry bit |
| so_in | input | 1 | Current summary-overflow bit |
| ovf_req | input | 1 | Request overflow recording |
| rec_req | input | 1 | Request condition-field update |
| out_valid | output | 1 | Result present |
| result | output | 32 | Sum |
| ca_we | output | 1 | Carry write-enable |
| ca_out | output | 1 | New carry |
| ov_we | output | 1 | Overflow write-enable |
| ov_out | output | 1 | New overflow |
| so_we | output | 1 | Summary-overflow write-enable |
| so_out | output | 1 | New summary overflow |
| cr_we | output | 1 | Condition-field write-enable |
| cr_out | output | 4 | Condition field {LT,GT,EQ,SO} |

## Verification
The properties that relate outputs to the previous cycle's inputs assume those inputs are stable from one falling edge to the next. They also assume `in_valid` is a clean level. The stimulus meets this by changing every input only on the falling clock edge. The checks on the subtract-from difference and on the shifted-immediate layout compare against the operands captured a cycle earlier, so they depend on the one-cycle latency. Every operation in the bench is issued back-to-back or after idle cycles and never during reset. The carry and summary-overflow inputs are taken from a bench-side copy of the architectural state, which keeps multiword chains consistent with what the pipe would feed back.

// File: rtl/tc_addsub_pkg.sv
// Package: shared operation codes and control types for the true-carry
// add/subtract unit. Assumes a 4-bit operation code.
package tc_addsub_pkg;

    typedef enum logic [3:0] {
        OP_ADD    = 4'd0,
        OP_ADDC   = 4'd1,
        OP_ADDE   = 4'd2,
        OP_ADDME  = 4'd3,
        OP_ADDZE  = 4'd4,
        OP_SUBF   = 4'd5,
        OP_SUBFC  = 4'd6,
        OP_SUBFE  = 4'd7,
        OP_SUBFME = 4'd8,
        OP_SUBFZE = 4'd9,
        OP_ADDI   = 4'd10,
        OP_ADDIS  = 4'd11,
        OP_ADDIC  = 4'd12,
        OP_SUBFIC = 4'd13
    } tc_op_e;

    // Source of the second addend
    typedef enum logic [2:0] {
        BSRC_REG   = 3'd0,
        BSRC_ONES  = 3'd1,
        BSRC_ZERO  = 3'd2,
        BSRC_SIMM  = 3'd3,
        BSRC_SHIMM = 3'd4
    } tc_bsrc_e;

    // Source of the carry-in term
    typedef enum logic [1:0] {
        CIN_ZERO = 2'd0,
        CIN_ONE  = 2'd1,
        CIN_CA   = 2'd2
    } tc_cin_e;

endpackage

// File: rtl/tc_addsub_decode.sv
// Module: tc_addsub_decode
// Turns the operation code into datapath controls: operand inversion,
// second-addend source, carry-in source, carry update and whether the
// overflow/record options apply. Assumes nothing about op validity;
// unlisted codes report known=0.
module tc_addsub_decode
    import tc_addsub_pkg::*;
(
    input  logic [3:0] op_code,
    output logic       known,
    output logic       inv_a,
    output logic       zero_a_ok,
    output tc_bsrc_e   bsrc,
    output tc_cin_e    cin_sel,
    output logic       ca_upd,
    output logic       opts_ok
);

    // Decode table for every operation form
    always_comb begin
        known     = 1'b1;
        inv_a     = 1'b0;
        zero_a_ok = 1'b0;
        bsrc      = BSRC_REG;
        cin_sel   = CIN_ZERO;
        ca_upd    = 1'b0;
        opts_ok   = 1'b1;
        case (op_code)
            OP_ADD:    ;
            OP_ADDC:   ca_upd = 1'b1;
            OP_ADDE: begin
                cin_sel = CIN_CA;
                ca_upd  = 1'b1;
            end
            OP_ADDME: begin
                bsrc    = BSRC_ONES;
                cin_sel = CIN_CA;
                ca_upd  = 1'b1;
            end
            OP_ADDZE: begin
                bsrc    = BSRC_ZERO;
                cin_sel = CIN_CA;
                ca_upd  = 1'b1;
            end
            OP_SUBF: begin
                inv_a   = 1'b1;
                cin_sel = CIN_ONE;
            end
            OP_SUBFC: begin
                inv_a   = 1'b1;
                cin_sel = CIN_ONE;
                ca_upd  = 1'b1;
            end
            OP_SUBFE: begin
                inv_a   = 1'b1;
                cin_sel = CIN_CA;
                ca_upd  = 1'b1;
            end
            OP_SUBFME: begin
                inv_a   = 1'b1;
                bsrc    = BSRC_ONES;
                cin_sel = CIN_CA;
                ca_upd  = 1'b1;
            end
            OP_SUBFZE: begin
                inv_a   = 1'b1;
                bsrc    = BSRC_ZERO;
                cin_sel = CIN_CA;
                ca_upd  = 1'b1;
            end
            OP_ADDI: begin
                zero_a_ok = 1'b1;
                bsrc      = BSRC_SIMM;
                opts_ok   = 1'b0;
            end
            OP_ADDIS: begin
                zero_a_ok = 1'b1;
                bsrc      = BSRC_SHIMM;
                opts_ok   = 1'b0;
            end
            OP_ADDIC: begin
                bsrc   = BSRC_SIMM;
                ca_upd = 1'b1;
            end
            OP_SUBFIC: begin
                inv_a   = 1'b1;
                bsrc    = BSRC_SIMM;
                cin_sel = CIN_ONE;
                ca_upd  = 1'b1;
            end
            default: begin
                known   = 1'b0;
                opts_ok = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/tc_addsub_operands.sv
// Module: tc_addsub_operands
// Builds the two addends and the carry-in from the decoded controls.
// Assumes WIDTH > IMM_W; the shifted immediate fills the top IMM_W bits.
module tc_addsub_operands
    import tc_addsub_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int IMM_W = 16
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [IMM_W-1:0] imm,
    input  logic             a_is_r0,
    input  logic             ca_in,
    input  logic             inv_a,
    input  logic             zero_a_ok,
    input  tc_bsrc_e         bsrc,
    input  tc_cin_e          cin_sel,
    output logic [WIDTH-1:0] add_x,
    output logic [WIDTH-1:0] add_y,
    output logic             add_cin
);

    localparam int EXT_W = WIDTH - IMM_W;

    logic [WIDTH-1:0] a_eff;
    logic [WIDTH-1:0] simm;
    logic [WIDTH-1:0] shimm;

    // First addend: register zero reads as zero where allowed, then optional inversion
    always_comb begin
        a_eff = (zero_a_ok && a_is_r0) ? '0 : opnd_a;
        add_x = inv_a ? ~a_eff : a_eff;
    end

    // Immediate expansions: sign-extended and shifted to the top
    always_comb begin
        simm  = {{EXT_W{imm[IMM_W-1]}}, imm};
        shimm = {imm, {EXT_W{1'b0}}};
    end

    // Second addend selection
    always_comb begin
        case (bsrc)
            BSRC_ONES:  add_y = '1;
            BSRC_ZERO:  add_y = '0;
            BSRC_SIMM:  add_y = simm;
            BSRC_SHIMM: add_y = shimm;
            default:    add_y = opnd_b;
        endcase
    end

    // Carry-in selection
    always_comb begin
        case (cin_sel)
            CIN_ONE: add_cin = 1'b1;
            CIN_CA:  add_cin = ca_in;
            default: add_cin = 1'b0;
        endcase
    end

endmodule

// File: rtl/tc_addsub_adder.sv
// Module: tc_addsub_adder
// One carry-propagate addition of two addends and a carry-in, giving the
// sum, the true carry out of the top bit and signed overflow.
// Assumes two's complement operands.
module tc_addsub_adder #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] add_x,
    input  logic [WIDTH-1:0] add_y,
    input  logic             add_cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             ovf
);

    localparam int SUM_W = WIDTH + 1;

    logic [SUM_W-1:0] wide;

    // Widened sum exposes the carry out
    always_comb begin
        wide = {1'b0, add_x} + {1'b0, add_y} + {{WIDTH{1'b0}}, add_cin};
        sum  = wide[WIDTH-1:0];
        cout = wide[WIDTH];
    end

    // Overflow: like-signed addends giving an unlike-signed sum
    always_comb begin
        ovf = (add_x[WIDTH-1] == add_y[WIDTH-1]) && (sum[WIDTH-1] != add_x[WIDTH-1]);
    end

endmodule

// File: rtl/tc_addsub_flags.sv
// Module: tc_addsub_flags
// Produces overflow, summary-overflow and condition-field values and
// their enables. Assumes 'active' is high only for a valid, known op.
module tc_addsub_flags #(
    parameter int WIDTH = 32
) (
    input  logic             active,
    input  logic             opts_ok,
    input  logic             ovf_req,
    input  logic             rec_req,
    input  logic             so_in,
    input  logic [WIDTH-1:0] sum,
    input  logic             ovf,
    output logic             ov_we,
    output logic             ov_val,
    output logic             so_we,
    output logic             so_val,
    output logic             cr_we,
    output logic [3:0]       cr_val
);

    logic so_now;
    logic is_neg;
    logic is_zero;

    // Overflow and sticky summary overflow
    always_comb begin
        ov_we  = active && opts_ok && ovf_req;
        ov_val = ov_we && ovf;
        so_we  = ov_we;
        so_val = ov_we && (so_in || ovf);
        so_now = ov_we ? (so_in || ovf) : so_in;
    end

    // Condition field {LT, GT, EQ, SO}
    always_comb begin
        is_neg  = sum[WIDTH-1];
        is_zero = (sum == '0);
        cr_we   = active && opts_ok && rec_req;
        cr_val  = cr_we ? {is_neg, !is_neg && !is_zero, is_zero, so_now} : 4'b0000;
    end

endmodule

// File: rtl/tc_addsub.sv
// Module: tc_addsub (top)
// True-carry add/subtract-from unit with one output register stage.
// Assumes the caller feeds back the carry and summary-overflow state it
// holds; synchronous active-low reset clears every output.
module tc_addsub
    import tc_addsub_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int IMM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [3:0]       op_code,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [IMM_W-1:0] imm,
    input  logic             a_is_r0,
    input  logic             ca_in,
    input  logic             so_in,
    input  logic             ovf_req,
    input  logic             rec_req,
    output logic             out_valid,
    output logic [WIDTH-1:0] result,
    output logic             ca_we,
    output logic             ca_out,
    output logic             ov_we,
    output logic             ov_out,
    output logic             so_we,
    output logic             so_out,
    output logic             cr_we,
    output logic [3:0]       cr_out
);

    logic             known;
    logic             inv_a;
    logic             zero_a_ok;
    tc_bsrc_e         bsrc;
    tc_cin_e          cin_sel;
    logic             ca_upd;
    logic             opts_ok;
    logic [WIDTH-1:0] add_x;
    logic [WIDTH-1:0] add_y;
    logic             add_cin;
    logic [WIDTH-1:0] sum;
    logic             cout;
    logic             ovf;
    logic             active;
    logic             ov_we_c;
    logic             ov_val_c;
    logic             so_we_c;
    logic             so_val_c;
    logic             cr_we_c;
    logic [3:0]       cr_val_c;

    tc_addsub_decode u_decode (
        .op_code   (op_code),
        .known     (known),
        .inv_a     (inv_a),
        .zero_a_ok (zero_a_ok),
        .bsrc      (bsrc),
        .cin_sel   (cin_sel),
        .ca_upd    (ca_upd),
        .opts_ok   (opts_ok)
    );

    tc_addsub_operands #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_operands (
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .imm       (imm),
        .a_is_r0   (a_is_r0),
        .ca_in     (ca_in),
        .inv_a     (inv_a),
        .zero_a_ok (zero_a_ok),
        .bsrc      (bsrc),
        .cin_sel   (cin_sel),
        .add_x     (add_x),
        .add_y     (add_y),
        .add_cin   (add_cin)
    );

    tc_addsub_adder #(.WIDTH(WIDTH)) u_adder (
        .add_x   (add_x),
        .add_y   (add_y),
        .add_cin (add_cin),
        .sum     (sum),
        .cout    (cout),
        .ovf     (ovf)
    );

    // Only a valid, known operation may drive anything
    always_comb begin
        active = in_valid && known;
    end

    tc_addsub_flags #(.WIDTH(WIDTH)) u_flags (
        .active  (active),
        .opts_ok (opts_ok),
        .ovf_req (ovf_req),
        .rec_req (rec_req),
        .so_in   (so_in),
        .sum     (sum),
        .ovf     (ovf),
        .ov_we   (ov_we_c),
        .ov_val  (ov_val_c),
        .so_we   (so_we_c),
        .so_val  (so_val_c),
        .cr_we   (cr_we_c),
        .cr_val  (cr_val_c)
    );

    // Output stage: one register per output, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            ca_we     <= 1'b0;
            ca_out    <= 1'b0;
            ov_we     <= 1'b0;
            ov_out    <= 1'b0;
            so_we     <= 1'b0;
            so_out    <= 1'b0;
            cr_we     <= 1'b0;
            cr_out    <= 4'b0000;
        end else begin
            out_valid <= in_valid;
            result    <= active ? sum : '0;
            ca_we     <= active && ca_upd;
            ca_out    <= active && ca_upd && cout;
            ov_we     <= ov_we_c;
            ov_out    <= ov_val_c;
            so_we     <= so_we_c;
            so_out    <= so_val_c;
            cr_we     <= cr_we_c;
            cr_out    <= cr_val_c;
        end
    end

endmodule

// File: rtl/tc_addsub_checker.sv
// Module: tc_addsub_checker
// Concurrent properties for tc_addsub, attached by bind below.
// Assumes inputs change away from the rising clock edge.
module tc_addsub_checker
    import tc_addsub_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int IMM_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [3:0]       op_code,
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic [IMM_W-1:0] imm,
    input logic             a_is_r0,
    input logic             out_valid,
    input logic [WIDTH-1:0] result,
    input logic             ca_we,
    input logic             ov_we,
    input logic             ov_out,
    input logic             so_we,
    input logic             so_out,
    input logic             cr_we,
    input logic [3:0]       cr_out
);

    localparam int EXT_W = WIDTH - IMM_W;

    p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(ca_we || ov_we || so_we || cr_we));

    // R4: subtract-from yields B minus A
    p_subf_diff_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == OP_SUBF) |=> result == ($past(opnd_b) - $past(opnd_a)));

    // R6: shifted immediate from register zero
    p_addis_r0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == OP_ADDIS && a_is_r0) |=>
            (result[EXT_W-1:0] == '0 && result[WIDTH-1:EXT_W] == $past(imm)));

    p_plain_no_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_code == OP_ADD || op_code == OP_SUBF ||
                      op_code == OP_ADDI || op_code == OP_ADDIS)) |=> !ca_we);

    p_imm_no_opts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_code == OP_ADDI || op_code == OP_ADDIS)) |=> (!ov_we && !cr_we));

    p_so_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_we && ov_out) |-> (so_we && so_out));

    p_so_with_ov_r9: assert property (@(posedge clk) disable iff (!rst_n)
        so_we == ov_we);

    p_cr_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cr_we |-> ($countones(cr_out[3:1]) == 1));

    p_cr_eq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cr_we |-> (cr_out[1] == (result == '0)));

    p_unknown_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code > 4'd13) |=>
            (result == '0 && !ca_we && !ov_we && !so_we && !cr_we));

endmodule

bind tc_addsub tc_addsub_checker #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_chk (.*);

// File: tb/tb_tc_addsub.sv
// Scoreboard bench for tc_addsub: a driver pushes expected items computed
// from the requirements; a monitor pops and compares on each valid output.
module tb_tc_addsub;
    import tc_addsub_pkg::*;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [31:0] res;
        logic        ca_we;
        logic        ca;
        logic        ov_we;
        logic        ov;
        logic        so_we;
        logic        so;
        logic        cr_we;
        logic [3:0]  cr;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [15:0] imm = '0;
    logic        a_is_r0 = 1'b0;
    logic        ca_in = 1'b0;
    logic        so_in = 1'b0;
    logic        ovf_req = 1'b0;
    logic        rec_req = 1'b0;
    logic        out_valid;
    logic [31:0] result;
    logic        ca_we, ca_out, ov_we, ov_out, so_we, so_out, cr_we;
    logic [3:0]  cr_out;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic ca_m = 1'b0;
    logic so_m = 1'b0;
    exp_t  q_exp[$];
    string q_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    tc_addsub dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .imm(imm), .a_is_r0(a_is_r0),
        .ca_in(ca_in), .so_in(so_in), .ovf_req(ovf_req), .rec_req(rec_req),
        .out_valid(out_valid), .result(result), .ca_we(ca_we), .ca_out(ca_out),
        .ov_we(ov_we), .ov_out(ov_out), .so_we(so_we), .so_out(so_out),
        .cr_we(cr_we), .cr_out(cr_out)
    );

    // Reference model from the requirements, with a wide signed overflow test
    function automatic exp_t model(input logic [3:0] op, input logic [31:0] a,
                                   input logic [31:0] b, input logic [15:0] im,
                                   input logic r0, input logic ca, input logic so,
                                   input logic ovr, input logic rec);
        exp_t e;
        logic [31:0] x, y, sx16;
        logic cin, cupd, opts, known;
        logic [32:0] full;
        longint wide;
        logic ovf, so_now;
        sx16 = {{16{im[15]}}, im};
        x = a; y = b; cin = 1'b0; cupd = 1'b1; opts = 1'b1; known = 1'b1;
        case (op)
            4'd0:  cupd = 1'b0;
            4'd1:  ;
            4'd2:  cin = ca;
            4'd3:  begin y = 32'hFFFF_FFFF; cin = ca; end
            4'd4:  begin y = 32'h0; cin = ca; end
            4'd5:  begin x = ~a; cin = 1'b1; cupd = 1'b0; end
            4'd6:  begin x = ~a; cin = 1'b1; end
            4'd7:  begin x = ~a; cin = ca; end
            4'd8:  begin x = ~a; y = 32'hFFFF_FFFF; cin = ca; end
            4'd9:  begin x = ~a; y = 32'h0; cin = ca; end
            4'd10: begin x = r0 ? 32'h0 : a; y = sx16; cupd = 1'b0; opts = 1'b0; end
            4'd11: begin x = r0 ? 32'h0 : a; y = {im, 16'h0000}; cupd = 1'b0; opts = 1'b0; end
            4'd12: y = sx16;
            4'd13: begin x = ~a; y = sx16; cin = 1'b1; end
            default: known = 1'b0;
        endcase
        full = {1'b0, x} + {1'b0, y} + {32'h0, cin};
        wide = longint'($signed(x)) + longint'($signed(y)) + longint'(cin);
        ovf  = (wide > 64'sd2147483647) || (wide < -64'sd2147483648);
        e = '0;
        if (known) begin
            e.res   = full[31:0];
            e.ca_we = cupd;
            e.ca    = cupd & full[32];
            e.ov_we = opts & ovr;
            e.ov    = e.ov_we & ovf;
            e.so_we = e.ov_we;
            e.so    = e.ov_we & (so | ovf);
            so_now  = e.ov_we ? (so | ovf) : so;
            e.cr_we = opts & rec;
            if (e.cr_we)
                e.cr = {full[31], !full[31] && (full[31:0] != 0), full[31:0] == 0, so_now};
        end
        return e;
    endfunction

    // Driver: present one operation at the falling edge, push its expectation
    task automatic drive(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] im, input logic r0, input logic ovr,
                         input logic rec, input string tag);
        exp_t e;
        @(negedge clk);
        e = model(op, a, b, im, r0, ca_m, so_m, ovr, rec);
        in_valid = 1'b1; op_code = op; opnd_a = a; opnd_b = b; imm = im;
        a_is_r0 = r0; ca_in = ca_m; so_in = so_m; ovf_req = ovr; rec_req = rec;
        if (e.ca_we) ca_m = e.ca;
        if (e.so_we) so_m = e.so;
        q_exp.push_back(e);
        q_tag.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic set_state(input logic ca, input logic so);
        ca_m = ca;
        so_m = so;
    endtask

    // Monitor: compare each valid output against the oldest expectation
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            exp_t act, e;
            string tag;
            act = {result, ca_we, ca_out, ov_we, ov_out, so_we, so_out, cr_we, cr_out};
            checks++;
            if (q_exp.size() == 0) begin
                fails++;
                $display("FAIL R2: unexpected out_valid, actual=%h expected=none", act);
            end else begin
                e = q_exp.pop_front();
                tag = q_tag.pop_front();
                if (act !== e) begin
                    fails++;
                    $display("FAIL %s: actual=%h expected=%h", tag, act, e);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset with a valid op presented
        in_valid = 1'b1; op_code = 4'd1; opnd_a = 32'hFFFF_FFFF; opnd_b = 32'h1;
        ovf_req = 1'b1; rec_req = 1'b1;
        repeat (3) @(negedge clk);
        checks++;
        if ({out_valid, result, ca_we, ca_out, ov_we, ov_out, so_we, so_out, cr_we, cr_out} !== '0) begin
            fails++;
            $display("FAIL R1: actual=%h expected=0", {out_valid, result, cr_out});
        end
        in_valid = 1'b0; ovf_req = 1'b0; rec_req = 1'b0;
        rst_n = 1'b1;
        idle(2);
        checks++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R2: idle out_valid actual=%b expected=0", out_valid);
        end

        // R3 add family
        drive(4'd0, 32'd5, 32'd7, 16'h0, 1'b0, 1'b0, 1'b0, "R3 add");
        drive(4'd1, 32'hFFFF_FFFF, 32'h1, 16'h0, 1'b0, 1'b0, 1'b0, "R3 R7 addc carry");
        drive(4'd2, 32'h1, 32'h2, 16'h0, 1'b0, 1'b0, 1'b0, "R3 adde");
        set_state(1'b0, 1'b0);
        drive(4'd3, 32'h0, 32'h0, 16'h0, 1'b0, 1'b0, 1'b0, "R3 addme ca0");
        set_state(1'b1, 1'b0);
        drive(4'd3, 32'h0, 32'h0, 16'h0, 1'b0, 1'b0, 1'b0, "R3 addme ca1");
        set_state(1'b1, 1'b0);
        drive(4'd4, 32'hFFFF_FFFF, 32'h0, 16'h0, 1'b0, 1'b0, 1'b0, "R3 addze");
        idle(1);
        // R4 subtract-from family
        drive(4'd5, 32'd10, 32'd3, 16'h0, 1'b0, 1'b0, 1'b0, "R4 subf");
        drive(4'd6, 32'd3, 32'd10, 16'h0, 1'b0, 1'b0, 1'b0, "R4 R7 subfc no borrow");
        drive(4'd6, 32'd10, 32'd3, 16'h0, 1'b0, 1'b0, 1'b0, "R4 R7 subfc carry0");
        drive(4'd7, 32'd1, 32'd1, 16'h0, 1'b0, 1'b0, 1'b0, "R4 subfe");
        set_state(1'b1, 1'b0);
        drive(4'd8, 32'h0, 32'h0, 16'h0, 1'b0, 1'b0, 1'b0, "R4 subfme");
        set_state(1'b1, 1'b0);
        drive(4'd9, 32'h0, 32'h0, 16'h0, 1'b0, 1'b0, 1'b0, "R4 subfze");
        // R5 R6 immediates
        drive(4'd10, 32'h1234_5678, 32'h0, 16'hFFF0, 1'b1, 1'b0, 1'b0, "R5 R6 addi r0");
        drive(4'd10, 32'h0000_0100, 32'h0, 16'hFFF0, 1'b0, 1'b0, 1'b0, "R5 addi reg");
        drive(4'd11, 32'hDEAD_BEEF, 32'h0, 16'h8001, 1'b1, 1'b0, 1'b0, "R5 R6 addis r0");
        drive(4'd11, 32'h0000_0003, 32'h0, 16'h0002, 1'b0, 1'b0, 1'b0, "R5 addis reg");
        drive(4'd12, 32'h0000_0005, 32'h0, 16'hFFFF, 1'b1, 1'b0, 1'b0, "R5 R6 addic uses reg");
        drive(4'd13, 32'd7, 32'h0, 16'd20, 1'b0, 1'b0, 1'b0, "R5 subfic");
        drive(4'd13, 32'd30, 32'h0, 16'd20, 1'b1, 1'b0, 1'b0, "R5 R6 subfic");
        // R8 R10 options ignored by addi/addis
        drive(4'd10, 32'h7FFF_FFFF, 32'h0, 16'h0001, 1'b0, 1'b1, 1'b1, "R8 R10 addi no opts");
        drive(4'd11, 32'h7FFF_FFFF, 32'h0, 16'h0001, 1'b0, 1'b1, 1'b1, "R8 R10 addis no opts");
        // R8 R9 overflow, sticky summary
        set_state(1'b0, 1'b0);
        drive(4'd0, 32'h7FFF_FFFF, 32'h1, 16'h0, 1'b0, 1'b1, 1'b1, "R8 R9 R10 add ovf");
        drive(4'd0, 32'h1, 32'h1, 16'h0, 1'b0, 1'b1, 1'b1, "R9 so stays set");
        set_state(1'b0, 1'b0);
        drive(4'd5, 32'h1, 32'h8000_0000, 16'h0, 1'b0, 1'b1, 1'b0, "R8 R9 subf ovf");
        set_state(1'b0, 1'b0);
        drive(4'd7, 32'h0, 32'h7FFF_FFFF, 16'h0, 1'b0, 1'b1, 1'b0, "R8 subfe ca0 no ovf");
        // R10 condition field: zero, negative, positive
        set_state(1'b0, 1'b0);
        drive(4'd5, 32'd9, 32'd9, 16'h0, 1'b0, 1'b0, 1'b1, "R10 eq");
        drive(4'd5, 32'd9, 32'd2, 16'h0, 1'b0, 1'b0, 1'b1, "R10 lt");
        drive(4'd0, 32'd9, 32'd2, 16'h0, 1'b0, 1'b0, 1'b1, "R10 gt");
        set_state(1'b0, 1'b1);
        drive(4'd0, 32'd9, 32'd2, 16'h0, 1'b0, 1'b0, 1'b1, "R10 so from input");
        // R11 undefined codes
        drive(4'd14, 32'd9, 32'd2, 16'h5, 1'b0, 1'b1, 1'b1, "R11 code14");
        drive(4'd15, 32'd9, 32'd2, 16'h5, 1'b0, 1'b1, 1'b1, "R11 code15");
        idle(2);

        // R3 R4 R7 multiword chains: 64-bit add and subtract with carry fed forward
        for (int k = 0; k < 40; k++) begin
            logic [31:0] al, ah, bl, bh;
            al = $urandom; ah = $urandom; bl = $urandom; bh = $urandom;
            if (k == 0) begin al = 32'hFFFF_FFFF; bl = 32'h1; end
            drive(4'd1, al, bl, 16'h0, 1'b0, 1'b0, 1'b0, "R3 R7 chain addc");
            drive(4'd2, ah, bh, 16'h0, 1'b0, 1'b1, 1'b1, "R3 R7 chain adde");
            drive(4'd6, al, bl, 16'h0, 1'b0, 1'b0, 1'b0, "R4 R7 chain subfc");
            drive(4'd7, ah, bh, 16'h0, 1'b0, 1'b1, 1'b1, "R4 R7 chain subfe");
            drive(4'd4, ah, 32'h0, 16'h0, 1'b0, 1'b0, 1'b0, "R3 chain addze");
            drive(4'd8, bh, 32'h0, 16'h0, 1'b0, 1'b0, 1'b0, "R4 chain subfme");
        end

        // R2..R11 sweep of all codes with idle gaps
        for (int k = 0; k < 600; k++) begin
            logic [31:0] ra, rb, sel;
            sel = $urandom;
            ra = sel[3] ? {sel[31], 31'($urandom)} : $urandom;
            rb = sel[4] ? 32'h0 : $urandom;
            drive(sel[23:20], ra, rb, 16'($urandom), sel[5], sel[6], sel[7], "R2 R8 R10 sweep");
            if (sel[10:8] == 3'd0) idle(1);
        end

        idle(3);
        checks++;
        if (q_exp.size() != 0) begin
            fails++;
            $display("FAIL R2: pending actual=%0d expected=0", q_exp.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule